// File: doc/BRIEF.md
# Interrupt Wake-Up and Idle Gate

This block stands between a set of asynchronous level request lines (interrupts and DMA requests from outside a processor subsystem) and the processor itself. Each line is first brought into the local clock domain through a flop chain. Each rising level is then turned into a single-cycle event pulse, which is the form the processor's event inputs accept. A level that stays high produces no more pulses until it falls and rises again.

A power controller asks the block to go idle with a level request and waits for an acknowledge. The block grants the acknowledge only on a clean boundary: no event is on the output and none is being launched. From then on it holds all event outputs low. While idle, any synchronized request that has not yet been delivered and whose wake-enable bit is set drives the wake-up output to the power controller. When the idle request is withdrawn, the acknowledge drops, the gate opens, and requests that are still high but were never delivered come out as events.

Top module: `wake_idle_gate`

## Requirements
- R1: While rst_ni is low, and after its release until inputs change, evt_o, idle_ack_o and wakeup_o are all zero.
- R2: Each req_i bit passes through a two-flop synchronizer. A rise of req_i[k] set up before rising clock edge n shows on evt_o[k] in the cycle after edge n+2, and not earlier.
- R3: Each synchronized rise of req_i[k] yields exactly one pulse on evt_o[k], one clock wide. A level held high yields no further pulse.
- R4: idle_ack_o rises one edge after a cycle in which idle_req_i is high, evt_o is zero and no event is being launched. An idle request that meets an event launch delays the acknowledge until that pulse has left, and the pulse is not lost.
- R5: While idle_ack_o is high, evt_o is all zero.
- R6: wakeup_o is high exactly when idle_ack_o is high and some bit k has a synchronized req high, not yet delivered, with wake_en_i[k] = 1. A bit with wake_en_i[k] = 0 never causes a wake-up.
- R7: A cycle with idle_ack_o high and idle_req_i low is followed by idle_ack_o low. A request held high across idle and never delivered pulses on evt_o in the cycle after the acknowledge falls.
- R8: A request that rises and falls again entirely while idle_ack_o is high produces no event after release.
- R9: Rises on several bits in the same cycle produce their pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_REQ | Asynchronous level requests |
| wake_en_i | input | N_REQ | Per-request wake-up enable mask |
| idle_req_i | input | 1 | Idle request from the power controller |
| idle_ack_o | output | 1 | Idle acknowledge; high while outputs are gated |
| wakeup_o | output | 1 | Wake-up event to the power controller |
| evt_o | output | N_REQ | Single-cycle event pulses to the processor |

## Verification
An idle request and an event launch can fall in the same cycle. The bench provokes this by raising idle_req_i exactly when a synchronized request reaches the edge detector. It then checks that the pulse still leaves on evt_o and that idle_ack_o rises only two edges later. Release of idle and the delivery of a request held through idle also coincide. The bench judges this by checking that the acknowledge falls and the pending pulse appears on successive edges. A behavioural reference model is compared against the design on every clock, including during a long randomized run where both kinds of overlap recur.

// File: rtl/wig_pkg.sv
package wig_pkg;
  typedef enum logic {
    GATE_RUN  = 1'b0,
    GATE_IDLE = 1'b1
  } gate_state_e;
endpackage

// File: rtl/wig_sync.sv
module wig_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wig_event.sv
module wig_event #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_s_i,
  input  logic         gate_i,
  output logic         launch_o,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] done_q, evt_q, fire;

  // a level is delivered once; done clears when the level falls
  assign fire     = req_s_i & ~done_q & {N{~gate_i}};
  assign pend_o   = req_s_i & ~done_q;
  assign launch_o = |fire;
  assign evt_o    = evt_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        done_q[k] <= 1'b0;
        evt_q[k]  <= 1'b0;
      end else begin
        done_q[k] <= req_s_i[k] & (done_q[k] | fire[k]);
        evt_q[k]  <= fire[k];
      end
    end
  end
endmodule

// File: rtl/wig_idle_ctl.sv
module wig_idle_ctl
  import wig_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        idle_req_i,
  input  logic        busy_i,
  output gate_state_e state_o
);
  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_RUN:  if (idle_req_i && !busy_i) state_d = GATE_IDLE;
      GATE_IDLE: if (!idle_req_i)           state_d = GATE_RUN;
      default:                              state_d = GATE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GATE_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/wake_idle_gate.sv
module wake_idle_gate
  import wig_pkg::*;
#(
  parameter int N_REQ       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] wake_en_i,
  input  logic             idle_req_i,
  output logic             idle_ack_o,
  output logic             wakeup_o,
  output logic [N_REQ-1:0] evt_o
);
  logic [N_REQ-1:0] req_s, pend, evt;
  logic             launch, gated;
  gate_state_e      state;

  wig_sync #(.N(N_REQ), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .async_i(req_i), .sync_o(req_s)
  );

  wig_event #(.N(N_REQ)) event_i (
    .clk_i, .rst_ni, .req_s_i(req_s), .gate_i(gated),
    .launch_o(launch), .pend_o(pend), .evt_o(evt)
  );

  // clean boundary: nothing launching and nothing on the output
  wig_idle_ctl ctl_i (
    .clk_i, .rst_ni, .idle_req_i, .busy_i(launch | (|evt)), .state_o(state)
  );

  assign gated      = (state == GATE_IDLE);
  assign idle_ack_o = gated;
  assign wakeup_o   = gated & |(pend & wake_en_i);
  assign evt_o      = evt;
endmodule

// File: rtl/wake_idle_gate_chk.sv
module wake_idle_gate_chk #(
  parameter int N_REQ = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             idle_req_i,
  input logic             idle_ack_o,
  input logic             wakeup_o,
  input logic [N_REQ-1:0] evt_o
);
  assert_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_ack_o |-> (evt_o == '0));

  assert_one_wide_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o != '0) |=> ((evt_o & $past(evt_o)) == '0));

  assert_clean_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_ack_o) |-> ($past(idle_req_i) && ($past(evt_o) == '0)));

  assert_wake_only_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wakeup_o |-> idle_ack_o);

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ack_o && !idle_req_i) |=> !idle_ack_o);
endmodule

bind wake_idle_gate wake_idle_gate_chk #(.N_REQ(N_REQ)) chk_i (
  .clk_i, .rst_ni, .idle_req_i, .idle_ack_o, .wakeup_o, .evt_o
);

// File: tb/wake_idle_gate_tb_top.sv
module wake_idle_gate_tb_top;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] wen = '0;
  logic         ireq = 1'b0;
  logic         ack, wake;
  logic [N-1:0] evt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_idle_gate #(.N_REQ(N), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wake_en_i(wen),
    .idle_req_i(ireq), .idle_ack_o(ack), .wakeup_o(wake), .evt_o(evt)
  );

  // behavioural reference: history of sampled requests plus delivery flags
  bit m_seen[N][$];
  bit m_given[N];
  bit m_evt[N];
  bit m_idle;

  function automatic bit m_synced(int k);
    // value sampled two edges ago
    if (m_seen[k].size() < 2) return 1'b0;
    return m_seen[k][m_seen[k].size()-2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        m_seen[k].delete(); m_given[k] = 0; m_evt[k] = 0;
      end
      m_idle = 0;
    end else begin
      bit any_launch, any_evt;
      bit launch[N];
      any_launch = 0; any_evt = 0;
      for (int k = 0; k < N; k++) begin
        launch[k] = m_synced(k) && !m_given[k] && !m_idle;
        if (launch[k]) any_launch = 1;
        if (m_evt[k]) any_evt = 1;
      end
      for (int k = 0; k < N; k++) begin
        m_given[k] = m_synced(k) && (m_given[k] || launch[k]);
        m_evt[k] = launch[k];
        m_seen[k].push_back(req[k]);
        if (m_seen[k].size() > 2) void'(m_seen[k].pop_front());
      end
      if (!m_idle && ireq && !any_launch && !any_evt) m_idle = 1;
      else if (m_idle && !ireq) m_idle = 0;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] e_evt;
      bit e_wake;
      e_wake = 0;
      for (int k = 0; k < N; k++) begin
        e_evt[k] = m_evt[k];
        if (m_idle && m_synced(k) && !m_given[k] && wen[k]) e_wake = 1;
      end
      check("R3 evt_o vs model", 32'(evt), 32'(e_evt));
      check("R4 idle_ack_o vs model", 32'(ack), 32'(m_idle));
      check("R6 wakeup_o vs model", 32'(wake), 32'(e_wake));
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    cyc(3);
    check("R1 evt_o in reset", 32'(evt), 0);
    check("R1 idle_ack_o in reset", 32'(ack), 0);
    check("R1 wakeup_o in reset", 32'(wake), 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 evt_o after reset", 32'(evt), 0);

    // R2 latency and R3 single pulse
    req[0] = 1'b1;
    cyc(2);
    check("R2 no early pulse", 32'(evt), 0);
    cyc(1);
    check("R2 pulse after third edge", 32'(evt), 32'h01);
    cyc(1);
    check("R3 pulse one clock wide", 32'(evt), 0);
    cyc(5);
    check("R3 held level no repeat", 32'(evt), 0);
    req[0] = 1'b0;
    cyc(3);

    // R9 simultaneous rises
    req = 8'b0010_0110;
    cyc(3);
    check("R9 same-cycle pulses", 32'(evt), 32'h26);
    req = '0;
    cyc(3);

    // R4 idle request meets event launch
    req[3] = 1'b1;
    cyc(2);
    ireq = 1'b1;
    cyc(1);
    check("R4 pulse kept on collision", 32'(evt), 32'h08);
    check("R4 no ack with pulse out", 32'(ack), 0);
    cyc(1);
    check("R4 ack still low", 32'(ack), 0);
    cyc(1);
    check("R4 ack after clean boundary", 32'(ack), 1);

    // R6 wake-up masking while idle, R5 gating
    wen = 8'h10;
    req[6] = 1'b1;
    cyc(2);
    check("R6 disabled bit no wake", 32'(wake), 0);
    check("R5 gated while idle", 32'(evt), 0);
    req[4] = 1'b1;
    cyc(2);
    check("R6 enabled bit wakes", 32'(wake), 1);
    req[6] = 1'b0;
    cyc(3);

    // R7 release, R8 lost short request
    ireq = 1'b0;
    cyc(1);
    check("R7 ack falls", 32'(ack), 0);
    cyc(1);
    check("R7 held request delivered", 32'(evt), 32'h10);
    cyc(1);
    check("R8 no late pulse", 32'(evt), 0);
    req = '0;
    cyc(4);

    // randomized run, model compared every clock
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) req[lfsr[6:4]] = ~req[lfsr[6:4]];
      if (lfsr[11:7] == 5'd3) ireq = ~ireq;
      if (lfsr[15:12] == 4'd9) wen = {lfsr[3:0], lfsr[11:8]};
      cyc(1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule